// File: doc/BRIEF.md
# SCSI Host Adapter Register Front End

This block presents a byte-wide register window to a CPU bus and turns it into the control and status wiring of a SCSI bus controller. Four consecutive port offsets from a base address are decoded. Offset 0 forwards data accesses to the controller. Offset 1 drives the bus reset, select and attention lines on a write and returns live bus status on a read. Offset 2 reports the two interrupt events and clears them. Offset 3 holds the interrupt mask.

Two events are latched. One is a phase event, taken from the controller's interrupt line. The other is a DMA end-of-process event, taken from the terminal-count input. Each event reaches a single registered interrupt output only when the global interrupt enable and that event's own mask bit are both set. The controller's DMA request is forwarded to a DMA channel only while the DMA enable bit is set.

Phase sequencing, the transfer engine, the DMA controller and the interrupt controller all sit outside this block. It is used by writing the control and mask bytes, polling or taking the interrupt, and clearing the event flags with write-one-to-clear.

Top module: `scsi_hregs`

## Requirements
- R1: A write at offset 0 pulses `ctl_data_wr` in the same cycle and presents `bus_wdata` on `ctl_wdata`. A read at offset 0 pulses `ctl_data_rd` and returns `ctl_rdata` on `bus_rdata` in the same cycle. No access to any other offset raises either strobe.
- R2: A write at offset 1 drives `ln_rst_o` from data bit 0, `ln_sel_o` from bit 2 and `ln_atn_o` from bit 4. The lines take the new values from the clock edge that accepts the write.
- R3: A read at offset 1 returns the following byte:
  - bit 7 = REQ, bit 6 = I/O, bit 5 = MSG, bit 4 = C/D, bit 3 = BSY;
  - bit 2 = constant 1;
  - bit 1 = OR of the two event flags;
  - bit 0 = constant 0.
- R4: A read at offset 3, or at any address outside the four-port window, returns 0xFF.
- R5: The phase flag is set on a rising edge of `ctl_irq` and cleared on its falling edge. The end-of-process flag behaves the same way on `dma_tc`. A read at offset 2 returns the phase flag on bit 1, the end-of-process flag on bit 0, and zeros above.
- R6: Writing offset 2 with a 1 in bit 1 clears the phase flag, and a 1 in bit 0 clears the end-of-process flag. A 0 bit leaves its flag unchanged. A rising source edge in the same cycle as the clear wins, and the flag ends up set.
- R7: `irq_o` is registered and follows the flags one cycle later. It equals control bit 6 AND ((mask bit 1 AND phase flag) OR (mask bit 0 AND end-of-process flag)).
- R8: After reset the following hold:
  - the control byte is 0, so all lines are low, DMA is gated off and interrupts are disabled;
  - the mask enables only the phase source (bit 1 set, bit 0 clear);
  - both flags are clear and `irq_o` is low.
- R9: `dma_req_o` equals `ctl_drq` while control bit 1 is set, and is held low otherwise.
- R10: Control bits 7, 5 and 3 affect no output: lines, DMA request and interrupt all behave as if those bits were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | CPU port address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data (combinational) |
| ctl_data_wr | output | 1 | Data write strobe to the controller |
| ctl_data_rd | output | 1 | Data read strobe to the controller |
| ctl_wdata | output | 8 | Data byte to the controller |
| ctl_rdata | input | 8 | Data byte from the controller |
| ln_req | input | 1 | Bus REQ line |
| ln_io | input | 1 | Bus I/O line |
| ln_msg | input | 1 | Bus MSG line |
| ln_cd | input | 1 | Bus C/D line |
| ln_bsy | input | 1 | Bus BSY line |
| ln_rst_o | output | 1 | Bus reset drive |
| ln_sel_o | output | 1 | Bus select drive |
| ln_atn_o | output | 1 | Bus attention drive |
| ctl_irq | input | 1 | Controller phase interrupt line |
| ctl_drq | input | 1 | Controller DMA request |
| dma_tc | input | 1 | DMA terminal count |
| dma_req_o | output | 1 | Gated DMA channel request |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A flag can see a set and a clear in the same cycle. The set comes from a source rising edge, and the clear comes from a write-one-to-clear at offset 2. To provoke this, the bench holds `ctl_irq` low, then raises it in the very cycle whose edge accepts a clear of bit 1. The offset-2 readback must then show the flag still set.

The bench also clears a flag while its source stays high. In that case the flag must drop and stay down with no new edge. `irq_o` must fall exactly one cycle after the clear.

// File: rtl/scsi_hregs_pkg.sv
package scsi_hregs_pkg;

  localparam int NPORT = 4;

  localparam logic [1:0] OFS_DATA  = 2'd0;
  localparam logic [1:0] OFS_CTRL  = 2'd1;
  localparam logic [1:0] OFS_EVT   = 2'd2;
  localparam logic [1:0] OFS_MASK  = 2'd3;

  // control byte bit positions
  localparam int CB_RST  = 0;
  localparam int CB_DMA  = 1;
  localparam int CB_SEL  = 2;
  localparam int CB_ATN  = 4;
  localparam int CB_GIE  = 6;

  // event indices: bit position in the event byte and in the mask byte
  localparam int EV_EOP   = 0;
  localparam int EV_PHASE = 1;
  localparam int NEV      = 2;

  localparam logic [NEV-1:0] MASK_RESET = 2'b10;
  localparam logic [7:0]     READ_IDLE  = 8'hFF;

  function automatic logic [7:0] pack_status(input logic req, input logic io,
                                             input logic msg, input logic cd,
                                             input logic bsy, input logic any_ev);
    return {req, io, msg, cd, bsy, 1'b1, any_ev, 1'b0};
  endfunction

  function automatic logic gate_irq(input logic gie, input logic [NEV-1:0] mask,
                                    input logic [NEV-1:0] flags);
    return gie & (|(mask & flags));
  endfunction

endpackage

// File: rtl/scsi_hregs_decode.sv
module scsi_hregs_decode
  import scsi_hregs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 32'h0120
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NPORT-1:0]  hit
);
  localparam logic [ADDR_W-1:0] BASE_A = BASE_ADDR[ADDR_W-1:0];

  logic [ADDR_W:0]   diff;
  logic [ADDR_W-1:0] offs;
  logic              in_win;

  assign diff   = {1'b0, bus_addr} - {1'b0, BASE_A};
  assign offs   = diff[ADDR_W-1:0];
  assign in_win = !diff[ADDR_W] && (offs[ADDR_W-1:2] == '0);

  for (genvar g = 0; g < NPORT; g++) begin : g_hit
    assign hit[g] = in_win && (offs[1:0] == 2'(g));
  end
endmodule

// File: rtl/scsi_hregs_ctrl.sv
module scsi_hregs_ctrl
  import scsi_hregs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_mask,
  input  logic [7:0]     wdata,
  output logic [7:0]     ctrl_q,
  output logic [NEV-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= MASK_RESET;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_mask) mask_q <= wdata[NEV-1:0];
    end
  end
endmodule

// File: rtl/scsi_hregs_evflag.sv
module scsi_hregs_evflag (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic clr,
  output logic flag,
  output logic rise
);
  logic src_d;
  logic fall;

  assign rise = src & ~src_d;
  assign fall = ~src & src_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      src_d <= src;
      if (rise)             flag <= 1'b1;
      else if (fall || clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_hregs.sv
module scsi_hregs
  import scsi_hregs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 32'h0120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ctl_data_wr,
  output logic              ctl_data_rd,
  output logic [7:0]        ctl_wdata,
  input  logic [7:0]        ctl_rdata,
  input  logic              ln_req,
  input  logic              ln_io,
  input  logic              ln_msg,
  input  logic              ln_cd,
  input  logic              ln_bsy,
  output logic              ln_rst_o,
  output logic              ln_sel_o,
  output logic              ln_atn_o,
  input  logic              ctl_irq,
  input  logic              ctl_drq,
  input  logic              dma_tc,
  output logic              dma_req_o,
  output logic              irq_o
);
  logic [NPORT-1:0] hit;
  logic [7:0]       ctrl_q;
  logic [NEV-1:0]   mask_q;
  logic [NEV-1:0]   flags;
  logic [NEV-1:0]   rises;
  logic [NEV-1:0]   ev_src;
  logic             wr_evt;
  logic             irq_q;
  logic             unused_ctrl;

  scsi_hregs_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .hit      (hit)
  );

  scsi_hregs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (bus_wr && hit[OFS_CTRL]),
    .wr_mask (bus_wr && hit[OFS_MASK]),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q)
  );

  assign ev_src[EV_PHASE] = ctl_irq;
  assign ev_src[EV_EOP]   = dma_tc;
  assign wr_evt           = bus_wr && hit[OFS_EVT];

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    scsi_hregs_evflag u_ev (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (ev_src[g]),
      .clr   (wr_evt && bus_wdata[g]),
      .flag  (flags[g]),
      .rise  (rises[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gate_irq(ctrl_q[CB_GIE], mask_q, flags);
  end

  assign irq_o       = irq_q;
  assign dma_req_o   = ctl_drq & ctrl_q[CB_DMA];
  assign ln_rst_o    = ctrl_q[CB_RST];
  assign ln_sel_o    = ctrl_q[CB_SEL];
  assign ln_atn_o    = ctrl_q[CB_ATN];
  assign unused_ctrl = ^{ctrl_q[7], ctrl_q[5], ctrl_q[3]};

  assign ctl_data_wr = bus_wr && hit[OFS_DATA];
  assign ctl_data_rd = bus_rd && hit[OFS_DATA];
  assign ctl_wdata   = bus_wdata;

  always_comb begin
    bus_rdata = READ_IDLE;
    if (hit[OFS_DATA])      bus_rdata = ctl_rdata;
    else if (hit[OFS_CTRL]) bus_rdata = pack_status(ln_req, ln_io, ln_msg, ln_cd,
                                                    ln_bsy, |flags);
    else if (hit[OFS_EVT])  bus_rdata = {{(8-NEV){1'b0}}, flags};
  end
endmodule

// File: rtl/scsi_hregs_chk.sv
module scsi_hregs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [3:0] hit,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] ctrl_q,
  input logic [1:0] flags,
  input logic [1:0] rises,
  input logic       ln_rst_o,
  input logic       ln_sel_o,
  input logic       ln_atn_o,
  input logic       irq_o
);
  AST_LINES_FOLLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit[1]) |=> (ln_rst_o == $past(bus_wdata[0]) && ln_sel_o == $past(bus_wdata[2])
                            && ln_atn_o == $past(bus_wdata[4]))); // R2

  AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit[1]) |-> (bus_rdata[2] && !bus_rdata[0])); // R3

  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rises[0] |=> flags[0]); // R5

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit[2] && bus_wdata[1] && !rises[1]) |=> !flags[1]); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ctrl_q[6])); // R7
endmodule

bind scsi_hregs scsi_hregs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .hit       (hit),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ctrl_q    (ctrl_q),
  .flags     (flags),
  .rises     (rises),
  .ln_rst_o  (ln_rst_o),
  .ln_sel_o  (ln_sel_o),
  .ln_atn_o  (ln_atn_o),
  .irq_o     (irq_o)
);

// File: tb/sim_scsi_hregs.sv
`timescale 1ns/1ps
module sim_scsi_hregs;
  localparam int          AW   = 16;
  localparam logic [15:0] BASE = 16'h0120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, ctl_wdata, ctl_rdata = 8'h00;
  logic ctl_data_wr, ctl_data_rd;
  logic ln_req = 0, ln_io = 0, ln_msg = 0, ln_cd = 0, ln_bsy = 0;
  logic ln_rst_o, ln_sel_o, ln_atn_o;
  logic ctl_irq = 0, ctl_drq = 0, dma_tc = 0;
  logic dma_req_o, irq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  scsi_hregs #(.ADDR_W(AW), .BASE_ADDR(32'(BASE))) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_data_wr(ctl_data_wr),
    .ctl_data_rd(ctl_data_rd), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ln_req(ln_req), .ln_io(ln_io), .ln_msg(ln_msg), .ln_cd(ln_cd), .ln_bsy(ln_bsy),
    .ln_rst_o(ln_rst_o), .ln_sel_o(ln_sel_o), .ln_atn_o(ln_atn_o),
    .ctl_irq(ctl_irq), .ctl_drq(ctl_drq), .dma_tc(dma_tc),
    .dma_req_o(dma_req_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] d);
    bus_addr = addr; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] addr, output logic [7:0] v);
    bus_addr = addr; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  // drop both sources long enough that both flags are cleared by falling edges
  task automatic quiet();
    ctl_irq = 0; dma_tc = 0;
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       exp_irq;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R8: reset state
    check("R8 lines", {5'b0, ln_rst_o, ln_sel_o, ln_atn_o}, 8'h00);
    check("R8 irq", {7'b0, irq_o}, 8'h00);
    ctl_drq = 1; #1;
    check("R8 dma gated", {7'b0, dma_req_o}, 8'h00);
    ctl_drq = 0;
    rd(BASE + 16'd2, v);
    check("R8 flags clear", v, 8'h00);
    wr(BASE + 16'd1, 8'h40);            // global enable only, mask at reset value
    dma_tc = 1; tick(); tick();
    check("R8 eop masked at reset", {7'b0, irq_o}, 8'h00);
    ctl_irq = 1; tick(); tick();
    check("R8 phase enabled at reset", {7'b0, irq_o}, 8'h01);
    wr(BASE + 16'd1, 8'h00);
    quiet();

    // R1: data port strobes and pass-through
    bus_addr = BASE; bus_wdata = 8'h5A; bus_wr = 1'b1; #1;
    check("R1 wr strobe", {7'b0, ctl_data_wr}, 8'h01);
    check("R1 wdata", ctl_wdata, 8'h5A);
    check("R1 no rd strobe", {7'b0, ctl_data_rd}, 8'h00);
    tick(); bus_wr = 1'b0;
    ctl_rdata = 8'hC3;
    bus_rd = 1'b1; #1;
    check("R1 rd strobe", {7'b0, ctl_data_rd}, 8'h01);
    check("R1 rdata", bus_rdata, 8'hC3);
    bus_rd = 1'b0;
    bus_addr = BASE + 16'd3; bus_wdata = 8'h00; bus_wr = 1'b1; #1;
    check("R1 no strobe off3", {7'b0, ctl_data_wr}, 8'h00);
    tick(); bus_wr = 1'b0;
    wr(BASE + 16'd3, 8'h02);            // restore default mask

    // R2: line drive sweep
    for (int i = 0; i < 8; i++) begin
      logic [2:0] b;
      b = 3'(i);
      wr(BASE + 16'd1, {3'b0, b[2], 1'b0, b[1], 1'b0, b[0]});
      check("R2 lines", {5'b0, ln_rst_o, ln_sel_o, ln_atn_o}, {5'b0, b[0], b[1], b[2]});
    end
    wr(BASE + 16'd1, 8'h00);

    // R3: status layout sweep, no flags
    for (int i = 0; i < 32; i++) begin
      logic [4:0] l;
      l = 5'(i);
      {ln_req, ln_io, ln_msg, ln_cd, ln_bsy} = l;
      rd(BASE + 16'd1, v);
      check("R3 status", v, {l, 3'b100});
    end
    {ln_req, ln_io, ln_msg, ln_cd, ln_bsy} = 5'b0;

    // R4: unmapped reads
    rd(BASE + 16'd3, v); check("R4 mask port", v, 8'hFF);
    rd(BASE + 16'd4, v); check("R4 above window", v, 8'hFF);
    rd(BASE - 16'd1, v); check("R4 below window", v, 8'hFF);

    // R5/R7: sweep enable x mask x flag combination
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 4; f++) begin
          logic [1:0] mm, ff;
          mm = 2'(m); ff = 2'(f);
          quiet();
          wr(BASE + 16'd1, (g != 0) ? 8'h40 : 8'h00);
          wr(BASE + 16'd3, {6'b0, mm});
          ctl_irq = ff[1]; dma_tc = ff[0];
          tick();
          rd(BASE + 16'd2, v);
          check("R5 event flags", v, {6'b0, ff});
          rd(BASE + 16'd1, v);
          check("R3 any flag", {7'b0, v[1]}, {7'b0, |ff});
          tick();
          exp_irq = (g != 0) && (|(mm & ff));
          check("R7 irq gating", {7'b0, irq_o}, {7'b0, exp_irq});
        end
      end
    end

    // R5: falling edge clears
    quiet();
    ctl_irq = 1; tick();
    ctl_irq = 0; tick();
    rd(BASE + 16'd2, v);
    check("R5 fall clears", v, 8'h00);

    // R6: write-one-to-clear, selective, and timing of irq drop
    quiet();
    wr(BASE + 16'd1, 8'h40);
    wr(BASE + 16'd3, 8'h03);
    ctl_irq = 1; dma_tc = 1; tick(); tick();
    check("R7 irq high", {7'b0, irq_o}, 8'h01);
    wr(BASE + 16'd2, 8'h00);
    rd(BASE + 16'd2, v);
    check("R6 zero write no effect", v, 8'h03);
    wr(BASE + 16'd2, 8'h01);
    rd(BASE + 16'd2, v);
    check("R6 clear eop only", v, 8'h02);
    wr(BASE + 16'd2, 8'h02);
    rd(BASE + 16'd2, v);
    check("R6 clear phase with source high", v, 8'h00);
    check("R7 irq still high one cycle", {7'b0, irq_o}, 8'h01);
    tick();
    check("R7 irq dropped", {7'b0, irq_o}, 8'h00);
    tick(); tick();
    rd(BASE + 16'd2, v);
    check("R6 no re-set without edge", v, 8'h00);

    // R6: rising edge in same cycle as clear wins
    quiet();
    bus_addr = BASE + 16'd2; bus_wdata = 8'h02; bus_wr = 1'b1;
    ctl_irq = 1;
    tick();
    bus_wr = 1'b0;
    rd(BASE + 16'd2, v);
    check("R6 rise beats clear", v, 8'h02);

    // R9: DMA request gate
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        wr(BASE + 16'd1, (e != 0) ? 8'h02 : 8'h00);
        ctl_drq = (d != 0); #1;
        check("R9 dma gate", {7'b0, dma_req_o}, {7'b0, (e != 0) && (d != 0)});
      end
    end
    ctl_drq = 0;

    // R10: spare control bits have no effect
    quiet();
    wr(BASE + 16'd3, 8'h03);
    wr(BASE + 16'd1, 8'hA8);
    ctl_drq = 1; ctl_irq = 1; dma_tc = 1;
    tick(); tick();
    check("R10 lines", {5'b0, ln_rst_o, ln_sel_o, ln_atn_o}, 8'h00);
    check("R10 dma", {7'b0, dma_req_o}, 8'h00);
    check("R10 irq", {7'b0, irq_o}, 8'h00);
    ctl_drq = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule